// File: doc/BRIEF.md
# USB Power Control Register with Isochronous Send Gate

This block is the byte-wide power-management control register of a USB on-the-go controller. Software reads and writes it over a simple register bus. Its layout and access rules depend on the role input. In host role it carries four fields: bus reset request, resume request, a suspend request that can only be set, and PHY power-down. In device role it adds two fields. One enables the data-line drivers. The other enables isochronous send gating. In device role the suspend field is read-only and follows the controller's own suspend detection.

The isochronous gate sits between the packet-ready event and the transmitter. When gating is off, a ready packet is released at once. When gating is on, the packet is held until the next start-of-frame token. An IN token that comes before that frame start is answered with a zero-length packet, and the real packet stays held.

Top module: `usb_pwr_ctl`

## Requirements
- R1: After reset every output is 0, and a read at the register offset (default 1) returns 0x00.
- R2: In host role a read returns {4'b0, bus-reset, resume, suspend, PHY-down} in bits 7..0, with bit 0 as PHY-down. A write sets bus-reset from bit 3, resume from bit 2 and PHY-down from bit 0. The matching outputs show the new values on the cycle after the write.
- R3: In device role a read returns gating-enable in bit 7, driver-enable in bit 6 and zeros in bits 5:4, with bits 3..0 as in host role. Bit 6 drives line_drv_en.
- R4: In host role, writing 1 to bit 1 sets suspend. Writing 0 to bit 1 leaves it unchanged.
- R5: In device role, writes to bit 1 are ignored. A susp_det pulse sets suspend on the next cycle.
- R6: Suspend clears on the cycle after bus_rst_det, and also on the cycle in which resume goes from 0 to 1.
- R7: In device role, a write of 1 to bit 2 sets resume only if suspend or resume is already 1. Otherwise resume reads 0. In host role resume simply follows the written bit.
- R8: With gating off, a tx_ready pulse gives a one-cycle pkt_go on the next cycle.
- R9: With gating on, tx_ready holds the packet. pkt_go fires on the cycle after the first sof_tok seen while the packet is held. A sof_tok in the same cycle as tx_ready does not release it.
- R10: While a packet is held, an in_tok without sof_tok gives a one-cycle zlp_go on the next cycle, and the packet stays held. pkt_go and zlp_go are never high together.
- R11: While a packet is held, if sof_tok and in_tok arrive in the same cycle, the result is pkt_go with no zlp_go.
- R12: Leaving device role clears bits 7:6 on the next cycle, so line_drv_en drops. A packet held at that time is released with pkt_go one cycle later.
- R13: A write to any other address changes nothing. A read at any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| role_dev | input | 1 | 1 = device role, 0 = host role |
| susp_det | input | 1 | Bus suspend detected (device role) |
| bus_rst_det | input | 1 | Bus reset detected |
| tx_ready | input | 1 | Packet ready pulse |
| sof_tok | input | 1 | Start-of-frame token pulse |
| in_tok | input | 1 | IN token pulse |
| sig_bus_reset | output | 1 | Reset signaling request |
| sig_resume | output | 1 | Resume signaling request |
| sig_suspend | output | 1 | Suspend state |
| phy_pwrdn | output | 1 | PHY power-down request |
| line_drv_en | output | 1 | Data-line driver enable (0 = high impedance) |
| pkt_go | output | 1 | Release the queued packet |
| zlp_go | output | 1 | Send a zero-length packet |

## Verification
The assertions assume that the event inputs are single-cycle pulses. They also assume that the bus write strobe is never asserted together with susp_det. Under those assumptions, the suspend checks can attribute each change to one cause. The bench keeps to these assumptions: it drives each event in its own cycle, except where same-cycle arrival is the case under test, namely SOF with IN, and SOF with tx_ready. The bench sweeps every write value in each role and carries a field-level expected model between writes.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;
  localparam int REG_W = 8;
  localparam int B_PD  = 0;
  localparam int B_SUS = 1;
  localparam int B_RES = 2;
  localparam int B_RST = 3;
  localparam int B_SC  = 6;
  localparam int B_ISO = 7;

  typedef enum logic {GATE_IDLE = 1'b0, GATE_HOLD = 1'b1} gate_e;

  typedef struct packed {
    logic iso;
    logic sc;
    logic rst;
    logic res;
    logic sus;
    logic pd;
  } pwr_fields_t;
endpackage

// File: rtl/usb_pwr_regs.sv
module usb_pwr_regs
  import usb_pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_dev,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             susp_det,
  input  logic             bus_rst_det,
  output pwr_fields_t      fld
);
  pwr_fields_t q, n;
  logic        res_start;
  logic        unused_rsvd;

  assign unused_rsvd = ^wdata[5:4];

  always_comb begin
    n = q;
    if (wr_hit) begin
      n.rst = wdata[B_RST];
      n.pd  = wdata[B_PD];
      if (role_dev) begin
        n.res = wdata[B_RES] & (q.res | q.sus);
        n.iso = wdata[B_ISO];
        n.sc  = wdata[B_SC];
      end else begin
        n.res = wdata[B_RES];
        if (wdata[B_SUS]) n.sus = 1'b1;
      end
    end
    if (role_dev && susp_det) n.sus = 1'b1;
    res_start = n.res & ~q.res;
    if (res_start || bus_rst_det) n.sus = 1'b0;
    if (!role_dev) begin
      n.iso = 1'b0;
      n.sc  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= n;
  end

  assign fld = q;

  assert_host_no_dev_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !role_dev |=> (!fld.sc && !fld.iso));

  assert_host_sus_w0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_dev && wr_hit && !wdata[B_SUS] && !wdata[B_RES] && !bus_rst_det && fld.sus)
    |=> fld.sus);

  assert_dev_sus_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (role_dev && wr_hit && !susp_det && !fld.sus) |=> !fld.sus);

  assert_resume_clears_sus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fld.res) |-> !fld.sus);

  assert_busrst_clears_sus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_det |=> !fld.sus);
endmodule

// File: rtl/usb_pwr_isogate.sv
module usb_pwr_isogate
  import usb_pwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic iso_en,
  input  logic tx_ready,
  input  logic sof_tok,
  input  logic in_tok,
  output logic pkt_go,
  output logic zlp_go
);
  gate_e st, st_n;
  logic  pkt_n, zlp_n;

  always_comb begin
    st_n  = st;
    pkt_n = 1'b0;
    zlp_n = 1'b0;
    unique case (st)
      GATE_IDLE: begin
        if (tx_ready) begin
          if (iso_en) st_n  = GATE_HOLD;
          else        pkt_n = 1'b1;
        end
      end
      GATE_HOLD: begin
        if (!iso_en || sof_tok) begin
          pkt_n = 1'b1;
          st_n  = GATE_IDLE;
        end else if (in_tok) begin
          zlp_n = 1'b1;
        end
      end
      default: st_n = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= GATE_IDLE;
      pkt_go <= 1'b0;
      zlp_go <= 1'b0;
    end else begin
      st     <= st_n;
      pkt_go <= pkt_n;
      zlp_go <= zlp_n;
    end
  end

  assert_single_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_go && zlp_go));

  assert_zlp_only_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    zlp_go |-> $past(iso_en));

  assert_sof_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GATE_HOLD && iso_en && sof_tok && in_tok) |=> (pkt_go && !zlp_go));

  assert_ungated_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GATE_IDLE && !iso_en && tx_ready) |=> pkt_go);
endmodule

// File: rtl/usb_pwr_rdmux.sv
module usb_pwr_rdmux
  import usb_pwr_pkg::*;
(
  input  logic             hit,
  input  logic             role_dev,
  input  pwr_fields_t      fld,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[B_PD]  = fld.pd;
      rdata[B_SUS] = fld.sus;
      rdata[B_RES] = fld.res;
      rdata[B_RST] = fld.rst;
      if (role_dev) begin
        rdata[B_SC]  = fld.sc;
        rdata[B_ISO] = fld.iso;
      end
    end
  end
endmodule

// File: rtl/usb_pwr_ctl.sv
module usb_pwr_ctl
  import usb_pwr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int REG_OFFSET = 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              role_dev,
  input  logic              susp_det,
  input  logic              bus_rst_det,
  input  logic              tx_ready,
  input  logic              sof_tok,
  input  logic              in_tok,
  output logic              sig_bus_reset,
  output logic              sig_resume,
  output logic              sig_suspend,
  output logic              phy_pwrdn,
  output logic              line_drv_en,
  output logic              pkt_go,
  output logic              zlp_go
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  logic        addr_hit;
  logic        wr_hit;
  pwr_fields_t fld;

  assign addr_hit = (bus_addr == OFFS);
  assign wr_hit   = bus_wr & addr_hit;

  usb_pwr_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .role_dev    (role_dev),
    .wr_hit      (wr_hit),
    .wdata       (bus_wdata),
    .susp_det    (susp_det),
    .bus_rst_det (bus_rst_det),
    .fld         (fld)
  );

  usb_pwr_isogate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .iso_en   (fld.iso),
    .tx_ready (tx_ready),
    .sof_tok  (sof_tok),
    .in_tok   (in_tok),
    .pkt_go   (pkt_go),
    .zlp_go   (zlp_go)
  );

  usb_pwr_rdmux u_rd (
    .hit      (addr_hit),
    .role_dev (role_dev),
    .fld      (fld),
    .rdata    (bus_rdata)
  );

  assign sig_bus_reset = fld.rst;
  assign sig_resume    = fld.res;
  assign sig_suspend   = fld.sus;
  assign phy_pwrdn     = fld.pd;
  assign line_drv_en   = fld.sc;

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[5:4] == 2'b00);

  assert_miss_reads_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (bus_rdata == '0));
endmodule

// File: tb/tb_usb_pwr_ctl.sv
module tb_usb_pwr_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       role_dev, susp_det, bus_rst_det, tx_ready, sof_tok, in_tok;
  logic       sig_bus_reset, sig_resume, sig_suspend, phy_pwrdn, line_drv_en;
  logic       pkt_go, zlp_go;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  logic m_rst, m_res, m_sus, m_pd, m_iso, m_sc;

  always #4 clk = ~clk;

  usb_pwr_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .role_dev(role_dev),
    .susp_det(susp_det), .bus_rst_det(bus_rst_det), .tx_ready(tx_ready),
    .sof_tok(sof_tok), .in_tok(in_tok), .sig_bus_reset(sig_bus_reset),
    .sig_resume(sig_resume), .sig_suspend(sig_suspend), .phy_pwrdn(phy_pwrdn),
    .line_drv_en(line_drv_en), .pkt_go(pkt_go), .zlp_go(zlp_go)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] exp_rd();
    return role_dev ? {m_iso, m_sc, 2'b00, m_rst, m_res, m_sus, m_pd}
                    : {4'b0000, m_rst, m_res, m_sus, m_pd};
  endfunction

  task automatic chk_state(input string req);
    chk(req, {8'h00, bus_rdata}, {8'h00, exp_rd()});
    chk(req, {11'd0, sig_bus_reset, sig_resume, sig_suspend, phy_pwrdn, line_drv_en},
             {11'd0, m_rst, m_res, m_sus, m_pd, m_sc});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_addr = 8'd1;
  endtask

  // expected-model update for a write at the register offset
  task automatic model_write(input logic [7:0] w);
    logic new_res, start;
    if (role_dev) new_res = w[2] & (m_res | m_sus);
    else          new_res = w[2];
    start = new_res & ~m_res;
    m_rst = w[3]; m_pd = w[0]; m_res = new_res;
    if (role_dev) begin m_iso = w[7]; m_sc = w[6]; end
    else if (w[1]) m_sus = 1'b1;
    if (start) m_sus = 1'b0;
  endtask

  task automatic pulse(input logic t, input logic s, input logic i);
    tx_ready = t; sof_tok = s; in_tok = i;
    tick();
    tx_ready = 0; sof_tok = 0; in_tok = 0;
  endtask

  task automatic chk_gate(input string req, input logic p, input logic z);
    chk(req, {14'd0, pkt_go, zlp_go}, {14'd0, p, z});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_addr = 8'd1; bus_wr = 0; bus_wdata = 0; role_dev = 0;
    susp_det = 0; bus_rst_det = 0; tx_ready = 0; sof_tok = 0; in_tok = 0;
    {m_rst, m_res, m_sus, m_pd, m_iso, m_sc} = '0;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk_state("R1");
    chk_gate("R1", 1'b0, 1'b0);

    // R2 R4 R6 R7: host sweep over all write values
    for (int v = 0; v < 256; v++) begin
      wr(8'd1, v[7:0]); model_write(v[7:0]);
      chk_state("R2_R4_R7");
      if (v[3:0] == 4'hA) begin
        bus_rst_det = 1; tick(); bus_rst_det = 0; m_sus = 0;
        chk_state("R6");
      end
    end

    // R3 R5 R6 R7: device sweep over all write values
    role_dev = 1; tick();
    chk_state("R3");
    for (int v = 0; v < 256; v++) begin
      if (v[1]) begin
        susp_det = 1; tick(); susp_det = 0;
        if (!m_res) m_sus = 1'b1;
        else        m_sus = 1'b1;
        chk_state("R5");
      end
      wr(8'd1, v[7:0]); model_write(v[7:0]);
      chk_state("R3_R5_R7");
    end

    // R6: bus reset clears suspend in device role
    wr(8'd1, 8'h00); model_write(8'h00);
    susp_det = 1; tick(); susp_det = 0; m_sus = 1;
    chk_state("R5");
    bus_rst_det = 1; tick(); bus_rst_det = 0; m_sus = 0;
    chk_state("R6");

    // R13: other address ignored on write, reads zero
    wr(8'd2, 8'hCF);
    bus_addr = 8'd2; #1;
    chk("R13", {8'h00, bus_rdata}, 16'h0000);
    bus_addr = 8'd1; #1;
    chk_state("R13");

    // R8: gating off
    wr(8'd1, 8'h40); model_write(8'h40);
    pulse(1, 0, 0); chk_gate("R8", 1, 0);
    tick();         chk_gate("R8", 0, 0);

    // R9 R10: gating on, IN before SOF
    wr(8'd1, 8'hC0); model_write(8'hC0);
    chk_state("R3");
    pulse(1, 0, 0); chk_gate("R9", 0, 0);
    tick(); tick(); chk_gate("R9", 0, 0);
    pulse(0, 0, 1); chk_gate("R10", 0, 1);
    tick();         chk_gate("R10", 0, 0);
    pulse(0, 0, 1); chk_gate("R10", 0, 1);
    pulse(0, 1, 0); chk_gate("R9", 1, 0);
    tick();         chk_gate("R9", 0, 0);

    // R10: IN while idle does nothing
    pulse(0, 0, 1); chk_gate("R10", 0, 0);

    // R11: SOF and IN together while held
    pulse(1, 0, 0); chk_gate("R9", 0, 0);
    pulse(0, 1, 1); chk_gate("R11", 1, 0);
    tick();         chk_gate("R11", 0, 0);

    // R9: SOF in the same cycle as ready does not release
    pulse(0, 1, 0); chk_gate("R9", 0, 0);
    pulse(1, 1, 0); chk_gate("R9", 0, 0);
    tick();         chk_gate("R9", 0, 0);
    pulse(0, 1, 0); chk_gate("R9", 1, 0);

    // R12: role change while a packet is held
    pulse(1, 0, 0); chk_gate("R9", 0, 0);
    role_dev = 0;
    tick(); m_iso = 0; m_sc = 0;
    chk_state("R12");
    chk_gate("R12", 0, 0);
    tick(); chk_gate("R12", 1, 0);
    tick(); chk_gate("R12", 0, 0);
    chk("R12", {8'h00, bus_rdata & 8'hF0}, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule